// File: doc/BRIEF.md
# Compare Pulse Timer with Sync and Trigger Gating

This block is a waveform generator built around its own up-counter. The counter advances on a tick from one of several clock-enable sources. Two compare values, a primary and a secondary, are checked against the counter each time it takes a new value. The resulting compare hits drive one output. That output can be a single pulse that then stays idle, a square wave that toggles on every primary hit, or a pulse-width modulated signal that rises on the primary value and falls on the secondary one.

A source-select field picks one line from a vector of internal event inputs. A value of zero leaves the counter free-running. A nonzero value puts the counter under control of the selected event, in one of two modes. In synchronous mode every event clears the counter, so the event spacing sets the waveform period. In trigger mode the counter stays frozen until the first event and then runs; a status bit shows which state the block is in. Two instances can be paired into one wider timer. The lower instance reports its counter wrap and its compare hits. The upper instance counts those wraps and accepts a compare hit only when the lower instance hits in the same cycle.

Software reaches the block through a single-cycle parallel write port and a combinational read port.

Top module: `ptmr_unit`

## Requirements
- R1: The 16-bit counter increments by one on each selected tick. It wraps from FFFFh to 0000h. A write to address 3 loads the counter with the written value, and a load wins over a tick in the same cycle.
- R2: Mode bits [5:3] pick the tick source: value k uses clk_tick[k] for k below 6. Values 6 and 7 pick no source, so the counter does not advance.
- R3: When mode bits [10:6] are zero the counter is free-running, and the event inputs have no effect on it.
- R4: With mode bits [10:6] equal to k (1 to 21) and mode bit 11 clear, evt_in[k-1] clears the counter to zero at the next edge, with priority over a tick. The values 22 to 31 select no event.
- R5: With mode bit 11 set and a nonzero source, the counter holds its value until the selected event arrives. The event sets the running flag (status bit 0 at address 4), and counting starts on the following cycle. Further events have no effect while the flag is set.
- R6: Writing address 4 with bit 0 clear clears the running flag, which freezes the counter again. Writing bit 0 set has no effect. Any write to the mode register (address 0) clears the running flag, the output and the done flag.
- R7: A primary or secondary hit occurs when the counter takes a value equal to that compare register through a tick or a synchronous clear. The output reacts on that same edge. A software load of the counter is never a hit.
- R8: In wave mode 1 (single pulse) the output rises on a primary hit and falls on the next secondary hit. That fall sets the done flag (status bit 1), and no further pulse appears until the mode register is written again.
- R9: In wave mode 2 the output toggles on every primary hit, and secondary hits have no effect.
- R10: In wave mode 3 (PWM) the output rises on a primary hit and falls on a secondary hit. When both hit in the same cycle the output goes low.
- R11: In wave mode 0, and in wave modes 4 to 7, the output is held low.
- R12: casc_wrap_o pulses in the cycle the counter wraps on a tick while mode bit 12 is set, and casc_hit_o reports {secondary hit, primary hit}. In an upper-half instance with bit 12 set, casc_wrap_i replaces the tick, and a hit needs the matching casc_hit_i bit together with counter equality.
- R13: rd_data returns the mode register at address 0 in bits [12:0], the primary value at address 1, the secondary value at 2, the counter at 3, and {done, running} at 4. Addresses 5 to 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_tick | input | 6 | Tick enables from the clock sources |
| evt_in | input | 21 | Internal event lines for sync or trigger |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data |
| casc_wrap_i | input | 1 | Wrap pulse from the lower neighbour |
| casc_hit_i | input | 2 | Hits from the lower neighbour {secondary, primary} |
| casc_wrap_o | output | 1 | Wrap pulse to the upper neighbour |
| casc_hit_o | output | 2 | Own hits {secondary, primary} |
| cmp_out | output | 1 | Compare waveform output |

## Verification
In free-running mode the waveform is driven with every-cycle ticks, with sparse random ticks on a chosen source, and with the stopped source values. This separates the clock-select decode from the counting itself, and a load just below FFFFh exposes the wrap. In synchronous mode, periodic pulses on the selected line arrive together with noise on the other lines, which shows whether only the chosen line clears the counter. Trigger sequences with repeated events and status writes tell the holding, running and re-armed states apart. Single-pulse, toggle and disabled modes, plus random cascade inputs, test that hits work only through the documented qualifiers.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int CKSEL_W = 3;
    localparam int SRC_W   = 5;
    localparam int ADDR_W  = 3;

    typedef enum logic [2:0] {
        WAVE_OFF    = 3'd0,
        WAVE_SINGLE = 3'd1,
        WAVE_TOGGLE = 3'd2,
        WAVE_PWM    = 3'd3
    } wave_e;

    // Mode register layout, MSB first: cascade, trigger, source, clock select, wave.
    typedef struct packed {
        logic               casc;
        logic               trig;
        logic [SRC_W-1:0]   src;
        logic [CKSEL_W-1:0] cksel;
        wave_e              wave;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [ADDR_W-1:0] {
        A_MODE = 3'd0,
        A_PRI  = 3'd1,
        A_SEC  = 3'd2,
        A_CNT  = 3'd3,
        A_STAT = 3'd4
    } addr_e;

endpackage

// File: rtl/ptmr_sel.sv
module ptmr_sel
    import ptmr_pkg::*;
#(
    parameter int NUM_CLK = 6,
    parameter int NUM_EVT = 21
) (
    input  logic [NUM_CLK-1:0] clk_tick,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [CKSEL_W-1:0] cksel,
    input  logic [SRC_W-1:0]   src,
    output logic               tick,
    output logic               sync_evt,
    output logic               src_none
);

    logic [NUM_CLK-1:0] ck_hit;
    logic [NUM_EVT-1:0] ev_hit;

    // One comparator per clock source; unmatched select values give no tick.
    for (genvar i = 0; i < NUM_CLK; i++) begin : g_ck
        assign ck_hit[i] = clk_tick[i] && (cksel == CKSEL_W'(i));
    end

    // Source value j+1 picks event line j; value zero picks nothing.
    for (genvar j = 0; j < NUM_EVT; j++) begin : g_ev
        assign ev_hit[j] = evt_in[j] && (src == SRC_W'(j + 1));
    end

    assign tick     = |ck_hit;
    assign sync_evt = |ev_hit;
    assign src_none = (src == '0);

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         sync_evt,
    input  logic         free_run,
    input  logic         trig_mode,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clr_run,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d,
    output logic         upd,
    output logic         wrap,
    output logic         run_q
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         run;
    } st_t;

    st_t st_q, st_d;
    logic inc;

    always_comb begin
        st_d = st_q;
        upd  = 1'b0;
        wrap = 1'b0;
        inc  = 1'b0;
        if (free_run) begin
            inc = tick;
        end else if (!trig_mode) begin
            if (sync_evt) begin
                st_d.cnt = '0;
                upd      = 1'b1;
            end else begin
                inc = tick;
            end
        end else begin
            if (st_q.run) begin
                inc = tick;
            end else if (sync_evt) begin
                st_d.run = 1'b1;
            end
        end
        if (inc) begin
            st_d.cnt = st_q.cnt + W'(1);
            upd      = 1'b1;
            wrap     = &st_q.cnt;
        end
        if (load) begin
            st_d.cnt = load_val;
            upd      = 1'b0;
            wrap     = 1'b0;
        end
        if (clr_run) begin
            st_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign cnt_d = st_d.cnt;
    assign run_q = st_q.run;

endmodule

// File: rtl/ptmr_wave.sv
module ptmr_wave
    import ptmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hit_pri,
    input  logic  hit_sec,
    input  wave_e wave,
    input  logic  rearm,
    output logic  out_q,
    output logic  done_q
);

    typedef struct packed {
        logic out;
        logic done;
    } wv_t;

    wv_t wv_q, wv_d;

    always_comb begin
        wv_d = wv_q;
        case (wave)
            WAVE_SINGLE: begin
                if (!wv_q.done) begin
                    if (hit_sec) begin
                        if (wv_q.out) begin
                            wv_d.out  = 1'b0;
                            wv_d.done = 1'b1;
                        end
                    end else if (hit_pri) begin
                        wv_d.out = 1'b1;
                    end
                end
            end
            WAVE_TOGGLE: begin
                if (hit_pri) begin
                    wv_d.out = !wv_q.out;
                end
            end
            WAVE_PWM: begin
                if (hit_sec) begin
                    wv_d.out = 1'b0;
                end else if (hit_pri) begin
                    wv_d.out = 1'b1;
                end
            end
            default: begin
                wv_d.out = 1'b0;
            end
        endcase
        if (rearm) begin
            wv_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wv_q <= '0;
        end else begin
            wv_q <= wv_d;
        end
    end

    assign out_q  = wv_q.out;
    assign done_q = wv_q.done;

endmodule

// File: rtl/ptmr_unit.sv
module ptmr_unit
    import ptmr_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int NUM_CLK    = 6,
    parameter int NUM_EVT    = 21,
    parameter bit UPPER_HALF = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CLK-1:0] clk_tick,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [CNT_W-1:0]   rd_data,
    input  logic               casc_wrap_i,
    input  logic [1:0]         casc_hit_i,
    output logic               casc_wrap_o,
    output logic [1:0]         casc_hit_o,
    output logic               cmp_out
);

    localparam int PAD_MODE = CNT_W - MODE_W;
    localparam int PAD_STAT = CNT_W - 2;

    typedef struct packed {
        mode_t            mode;
        logic [CNT_W-1:0] pri;
        logic [CNT_W-1:0] sec;
    } regs_t;

    regs_t regs_q, regs_d;

    logic             tick_own, tick, sync_evt, src_none;
    logic             wr_mode, wr_stat, load_cnt, clr_run, up_casc;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             upd, wrap, run_q, done_q;
    logic             eq_pri, eq_sec, hit_pri, hit_sec;

    // Register file
    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_addr)
                A_MODE:  regs_d.mode = mode_t'(wr_data[MODE_W-1:0]);
                A_PRI:   regs_d.pri  = wr_data;
                A_SEC:   regs_d.sec  = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign wr_mode  = wr_en && (wr_addr == A_MODE);
    assign wr_stat  = wr_en && (wr_addr == A_STAT);
    assign load_cnt = wr_en && (wr_addr == A_CNT);
    assign clr_run  = wr_mode || (wr_stat && !wr_data[0]);
    assign up_casc  = UPPER_HALF && regs_q.mode.casc;

    ptmr_sel #(
        .NUM_CLK (NUM_CLK),
        .NUM_EVT (NUM_EVT)
    ) u_sel (
        .clk_tick (clk_tick),
        .evt_in   (evt_in),
        .cksel    (regs_q.mode.cksel),
        .src      (regs_q.mode.src),
        .tick     (tick_own),
        .sync_evt (sync_evt),
        .src_none (src_none)
    );

    // The upper half of a pair counts wraps of the lower half.
    assign tick = up_casc ? casc_wrap_i : tick_own;

    ptmr_count #(
        .W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sync_evt  (sync_evt),
        .free_run  (src_none),
        .trig_mode (regs_q.mode.trig),
        .load      (load_cnt),
        .load_val  (wr_data),
        .clr_run   (clr_run),
        .cnt_q     (cnt_q),
        .cnt_d     (cnt_d),
        .upd       (upd),
        .wrap      (wrap),
        .run_q     (run_q)
    );

    // Compare against the value the counter is about to take.
    assign eq_pri  = (cnt_d == regs_q.pri);
    assign eq_sec  = (cnt_d == regs_q.sec);
    assign hit_pri = eq_pri && (up_casc ? casc_hit_i[0] : upd);
    assign hit_sec = eq_sec && (up_casc ? casc_hit_i[1] : upd);

    ptmr_wave u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_pri (hit_pri),
        .hit_sec (hit_sec),
        .wave    (regs_q.mode.wave),
        .rearm   (wr_mode),
        .out_q   (cmp_out),
        .done_q  (done_q)
    );

    assign casc_wrap_o = wrap && regs_q.mode.casc;
    assign casc_hit_o  = {hit_sec, hit_pri};

    always_comb begin
        case (rd_addr)
            A_MODE:  rd_data = {{PAD_MODE{1'b0}}, regs_q.mode};
            A_PRI:   rd_data = regs_q.pri;
            A_SEC:   rd_data = regs_q.sec;
            A_CNT:   rd_data = cnt_q;
            A_STAT:  rd_data = {{PAD_STAT{1'b0}}, done_q, run_q};
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt,
    input logic         tick,
    input logic         sync_evt,
    input logic         free_run,
    input logic         trig_mode,
    input logic         load,
    input logic         run,
    input logic         done,
    input logic         out,
    input logic         wrap_o
);

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (free_run && tick && !load) |=> (cnt == $past(cnt) + W'(1)));

    p_free_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (free_run && !tick && !load) |=> $stable(cnt));

    p_sync_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!free_run && !trig_mode && sync_evt && !load) |=> (cnt == '0));

    p_trig_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!free_run && trig_mode && !run && !load) |=> $stable(cnt));

    p_done_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out);

    p_wrap_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt == '0));

endmodule

bind ptmr_unit ptmr_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt_q),
    .tick      (tick),
    .sync_evt  (sync_evt),
    .free_run  (src_none),
    .trig_mode (regs_q.mode.trig),
    .load      (load_cnt),
    .run       (run_q),
    .done      (done_q),
    .out       (cmp_out),
    .wrap_o    (casc_wrap_o)
);

// File: tb/ptmr_unit_tb.sv
`timescale 1ns/1ps
module ptmr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  clk_tick = '0;
    logic [20:0] evt_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        casc_wrap_i = 1'b0;
    logic [1:0]  casc_hit_i = '0;
    logic        casc_wrap_o;
    logic [1:0]  casc_hit_o;
    logic        cmp_out;

    always #10 clk = ~clk;

    ptmr_unit #(.UPPER_HALF(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_tick(clk_tick), .evt_in(evt_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .casc_wrap_i(casc_wrap_i), .casc_hit_i(casc_hit_i),
        .casc_wrap_o(casc_wrap_o), .casc_hit_o(casc_hit_o), .cmp_out(cmp_out)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    ended  = 1'b0;
    string cur_req = "R13";

    // Reference model state
    int        m_cnt = 0, m_pri = 0, m_sec = 0;
    bit [12:0] m_mode = '0;
    bit        m_run = 0, m_out = 0, m_done = 0;

    // Stimulus knobs
    int k_tick = 0;      // 0 none, 1 all, 2 random
    int k_per  = 0;      // period of pulses on k_mask, 0 = none
    int k_mask = 0;
    bit k_noise = 0;     // random pulses on lines outside k_mask
    bit k_casc = 0;      // random cascade inputs

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit [15:0] mk_mode(bit casc, bit trig, int src, int ck, int wave);
        return {3'b000, casc, trig, 5'(src), 3'(ck), 3'(wave)};
    endfunction

    function automatic void model_eval(output int nxt, output bit upd, output bit wrp,
                                       output bit hp, output bit hs, output bit nrun);
        int ck_sel = int'(m_mode[5:3]);
        int src    = int'(m_mode[10:6]);
        bit trig   = m_mode[11];
        bit casc   = m_mode[12];
        bit ck, se, inc;
        ck  = (ck_sel < 6) ? clk_tick[ck_sel] : 1'b0;
        if (casc) ck = casc_wrap_i;
        se  = (src >= 1 && src <= 21) ? evt_in[src-1] : 1'b0;
        nxt = m_cnt; upd = 0; wrp = 0; nrun = m_run; inc = 0;
        if (src == 0) inc = ck;
        else if (!trig) begin
            if (se) begin nxt = 0; upd = 1; end
            else inc = ck;
        end else begin
            if (m_run) inc = ck;
            else if (se) nrun = 1;
        end
        if (inc) begin
            wrp = (m_cnt == 65535);
            nxt = (m_cnt + 1) % 65536;
            upd = 1;
        end
        if (wr_en && wr_addr == 3) begin nxt = int'(wr_data); upd = 0; wrp = 0; end
        if (wr_en && (wr_addr == 0 || (wr_addr == 4 && !wr_data[0]))) nrun = 0;
        if (casc) begin
            hp = casc_hit_i[0] && (nxt == m_pri);
            hs = casc_hit_i[1] && (nxt == m_sec);
        end else begin
            hp = upd && (nxt == m_pri);
            hs = upd && (nxt == m_sec);
        end
    endfunction

    function automatic int model_read(int a);
        case (a)
            0: return int'(m_mode);
            1: return m_pri;
            2: return m_sec;
            3: return m_cnt;
            4: return (int'(m_done) << 1) | int'(m_run);
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        int nxt; bit upd, wrp, hp, hs, nrun;
        bit no, nd;
        model_eval(nxt, upd, wrp, hp, hs, nrun);
        no = m_out; nd = m_done;
        case (int'(m_mode[2:0]))
            1: if (!m_done) begin
                   if (hs) begin
                       if (m_out) begin no = 0; nd = 1; end
                   end else if (hp) no = 1;
               end
            2: if (hp) no = !m_out;
            3: if (hs) no = 0; else if (hp) no = 1;
            default: no = 0;
        endcase
        if (wr_en) begin
            case (int'(wr_addr))
                0: begin m_mode = wr_data[12:0]; no = 0; nd = 0; end
                1: m_pri = int'(wr_data);
                2: m_sec = int'(wr_data);
                default: ;
            endcase
        end
        m_cnt = nxt; m_run = nrun; m_out = no; m_done = nd;
    endtask

    task automatic check_all();
        int nxt; bit upd, wrp, hp, hs, nrun;
        model_eval(nxt, upd, wrp, hp, hs, nrun);
        chk(cur_req, "cmp_out", int'(cmp_out), int'(m_out));
        chk(cur_req, "rd_data", int'(rd_data), model_read(int'(rd_addr)));
        chk(cur_req, "casc_wrap_o", int'(casc_wrap_o), int'(m_mode[12] && wrp));
        chk(cur_req, "casc_hit_o", int'(casc_hit_o), int'({hs, hp}));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            int e = 0;
            case (k_tick)
                1: clk_tick = '1;
                2: clk_tick = 6'($urandom);
                default: clk_tick = '0;
            endcase
            if (k_noise) e = int'($urandom) & 32'h1FFFFF & ~k_mask;
            if (k_per != 0 && (i % k_per) == k_per - 1) e = e | k_mask;
            evt_in = 21'(e);
            if (k_casc) begin
                casc_wrap_i = 1'($urandom);
                casc_hit_i  = 2'($urandom);
            end
            rd_addr = 3'($urandom);
            cyc();
        end
        evt_in = '0;
    endtask

    task automatic pulse_evt(int line);
        evt_in = 21'(1 << line);
        cyc();
        evt_in = '0;
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=%0d exp=done", checks);
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset state: all registers read zero, output low (R13, R11)
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            chk("R13", "reset rd_data", int'(rd_data), 0);
        end
        chk("R11", "reset cmp_out", int'(cmp_out), 0);

        // R10 and R1: PWM in free-running mode, then wrap from near FFFFh
        cur_req = "R10";
        wr(1, 3); wr(2, 7);
        wr(0, mk_mode(0, 0, 0, 0, 3));
        k_tick = 1;
        run(30);
        cur_req = "R1";
        wr(3, 16'hFFF0);
        run(40);

        // R2: clock source selection
        cur_req = "R2";
        wr(1, 5); wr(2, 12);
        wr(0, mk_mode(0, 0, 0, 2, 3));
        wr(3, 0);
        k_tick = 2;
        run(60);
        wr(0, mk_mode(0, 0, 0, 5, 3));
        run(60);
        wr(0, mk_mode(0, 0, 0, 6, 3));
        run(20);
        wr(0, mk_mode(0, 0, 0, 7, 3));
        run(20);

        // R3: free-running ignores event lines
        cur_req = "R3";
        wr(0, mk_mode(0, 0, 0, 0, 3));
        k_tick = 1; k_noise = 1; k_mask = 0;
        run(40);
        k_noise = 0;

        // R4: synchronous clear from line 4, noise elsewhere, random ticks
        cur_req = "R4";
        wr(1, 2); wr(2, 6);
        wr(0, mk_mode(0, 0, 5, 0, 3));
        k_tick = 1; k_per = 10; k_mask = 1 << 4; k_noise = 1;
        run(60);
        k_tick = 2;
        run(60);
        // source 25 selects nothing: never cleared
        wr(0, mk_mode(0, 0, 25, 0, 3));
        k_tick = 1; k_mask = 0; k_per = 0;
        run(30);
        k_noise = 0;

        // R5: trigger mode waits on line 20
        cur_req = "R5";
        wr(3, 100);
        wr(1, 104); wr(2, 110);
        wr(0, mk_mode(0, 1, 21, 0, 3));
        k_tick = 1; k_noise = 1; k_mask = 1 << 20;
        run(12);
        k_noise = 0;
        rd_addr = 3'd4;
        pulse_evt(20);
        run(20);
        pulse_evt(20);
        run(5);

        // R6: status writes and mode rewrite
        cur_req = "R6";
        wr(4, 1);
        rd_addr = 3'd4; cyc();
        wr(4, 0);
        rd_addr = 3'd3;
        run(8);
        pulse_evt(20);
        run(6);
        wr(0, mk_mode(0, 1, 21, 0, 3));
        run(8);

        // R7: loads never hit; ticks do
        cur_req = "R7";
        wr(1, 40); wr(2, 45);
        wr(0, mk_mode(0, 0, 0, 0, 3));
        k_tick = 0;
        wr(3, 40);
        run(4);
        k_tick = 1;
        wr(3, 39);
        run(10);
        wr(3, 45);
        k_tick = 0;
        run(3);

        // R8: single pulse, no repeat until mode rewrite
        cur_req = "R8";
        wr(1, 4); wr(2, 9);
        wr(0, mk_mode(0, 0, 0, 0, 1));
        wr(3, 0);
        k_tick = 1;
        run(20);
        wr(3, 0);
        run(20);
        wr(0, mk_mode(0, 0, 0, 0, 1));
        wr(3, 0);
        run(20);

        // R9: toggle on primary hits with a synchronous period
        cur_req = "R9";
        wr(1, 5); wr(2, 2);
        wr(0, mk_mode(0, 0, 1, 0, 2));
        k_per = 8; k_mask = 1;
        run(50);
        k_per = 0; k_mask = 0;

        // R10: equal compare values keep PWM low
        cur_req = "R10";
        wr(1, 6); wr(2, 6);
        wr(0, mk_mode(0, 0, 0, 0, 3));
        wr(3, 0);
        run(20);

        // R11: disabled and reserved wave modes
        cur_req = "R11";
        wr(1, 2); wr(2, 8);
        for (int w = 4; w < 8; w++) begin
            wr(0, mk_mode(0, 0, 0, 0, w));
            wr(3, 0);
            run(12);
        end
        wr(0, mk_mode(0, 0, 0, 0, 0));
        wr(3, 0);
        run(12);

        // R12: upper-half cascade operation
        cur_req = "R12";
        wr(1, 2); wr(2, 4);
        wr(0, mk_mode(1, 0, 0, 0, 3));
        wr(3, 0);
        k_tick = 1; k_casc = 1;
        run(80);
        wr(3, 16'hFFFE);
        run(30);
        k_casc = 0; casc_wrap_i = 0; casc_hit_i = '0;

        // R13: register map, including ignored addresses
        cur_req = "R13";
        k_tick = 0;
        wr(5, 16'hBEEF); wr(6, 16'h1234); wr(7, 16'hFFFF);
        wr(1, 16'hA5A5); wr(2, 16'h5A5A); wr(3, 16'h0F0F);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            cyc();
        end

        finish_up();
    end

endmodule